// File: doc/BRIEF.md
# Configurable Pixel Channel Extractor

This block takes one packed pixel word per cycle and returns its red, green and blue components, each as an 8-bit value. A pixel word holds one to four bytes. A format code gives the number of bytes in use. For each of the three channels, a select word gives a bit offset and a field length. The block shifts the pixel word down by the offset and keeps the requested number of bits. It then moves that field to the top of an 8-bit lane and fills the free low bits by repeating the field's own bits from the top down. This lets a 5-bit or 6-bit component reach full scale.

The result is registered, so each accepted pixel appears on the outputs exactly one clock later with a one-cycle valid pulse. The outputs keep their last value until the next pixel is accepted. The format code and the select words are read only in the cycle a pixel is accepted, so software may change them between pixels at any time. A small two-state machine tracks the output stage. It starts in ST_IDLE after reset. An accepted pixel moves it to ST_EMIT (transition GO_EMIT). A further pixel keeps it in ST_EMIT (STAY_EMIT). A cycle with no pixel returns it to ST_IDLE (GO_IDLE). While the input is quiet it remains in ST_IDLE (STAY_IDLE).

Top module: `pce_pixel_extract`

## Requirements
- R1: After reset `out_vld` is 0 and `out_r`, `out_g` and `out_b` are all 0x00.
- R2: A pixel accepted with `px_vld` high at a rising edge appears on the outputs after exactly one clock, with `out_vld` high for exactly one cycle per accepted pixel, including back-to-back pixels.
- R3: When `px_vld` is low, the channel outputs hold their last values, and changes to `fmt_bpp_m1` or the select words in that time have no effect until the next accepted pixel.
- R4: `fmt_bpp_m1` holds the bytes per pixel minus one (0 to 3 = 1 to 4 bytes; codes 4 to 7 mean 4 bytes). Pixel bits at or above 8 times the byte count read as zero.
- R5: Each select word carries the field length in bits [11:8] and the bit offset in bits [7:0]. The field is bits offset to offset+length-1 of the pixel, and bits past the top of the pixel word read as zero.
- R6: A field shorter than 8 bits is placed in the upper bits of the channel output. Each lower output bit i (counted from bit 7 downward) copies field bit length-1-(i mod length).
- R7: A length of 0 gives a channel of 0x00. A length above 8 is treated as 8.
- R8: With 2 bytes per pixel, blue length 5 at offset 0, green length 6 at offset 5 and red length 5 at offset 11, the 16-bit value 0x8410 gives red 0x84, green 0x82 and blue 0x84. In this layout each channel's offset is the sum of the lengths of the fields below it.
- R9: With 4 bytes per pixel and 8-bit channels at offsets 16 (red), 8 (green) and 0 (blue), the byte at offset 24 has no effect on any channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| px_vld | input | 1 | Pixel word valid this cycle |
| px_word | input | 32 | Packed pixel word, byte 0 in bits [7:0] |
| fmt_bpp_m1 | input | 3 | Bytes per pixel minus one |
| red_sel | input | 12 | Red length [11:8], offset [7:0] |
| grn_sel | input | 12 | Green length [11:8], offset [7:0] |
| blu_sel | input | 12 | Blue length [11:8], offset [7:0] |
| out_vld | output | 1 | Channel outputs updated this cycle |
| out_r | output | 8 | Red channel, 8 bits |
| out_g | output | 8 | Green channel, 8 bits |
| out_b | output | 8 | Blue channel, 8 bits |

## Verification
The bench sweeps every field length from 0 to 15 at several offsets. A design that shifted instead of repeating bits would produce 0x80 instead of 0xFF for a 1-bit field. A design with the wrong repeat period would get the 3-bit and 5-bit patterns wrong. It places fields across the top of the active byte count and across the top of the word. A design that forgot the byte mask would leak a 24-bit pixel's fourth byte into the red channel. It also runs back-to-back pixels and changes the selects between pixels. A design that sampled the selects late, or let the outputs follow the inputs, would show the new setting on an old pixel or drop the second of two adjacent valid pulses.

// File: rtl/pce_pkg.sv
package pce_pkg;
    localparam int CH_W    = 8;
    localparam int SEL_W   = 12;
    localparam int LEN_LSB = 8;
    localparam int LEN_W   = 4;
    localparam int OFF_W   = 8;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_EMIT = 1'b1
    } pce_state_e;

    typedef struct packed {
        logic [CH_W-1:0] r;
        logic [CH_W-1:0] g;
        logic [CH_W-1:0] b;
    } pce_rgb_t;
endpackage

// File: rtl/pce_width_mask.sv
module pce_width_mask #(
    parameter int PX_BYTES = 4
) (
    input  logic [PX_BYTES*8-1:0] word_in,
    input  logic [2:0]            bpp_m1,
    output logic [PX_BYTES*8-1:0] word_kept
);
    localparam logic [2:0] MAX_CODE = 3'(PX_BYTES - 1);

    logic [2:0] code_eff;
    assign code_eff = (bpp_m1 > MAX_CODE) ? MAX_CODE : bpp_m1;

    for (genvar b = 0; b < PX_BYTES; b++) begin : g_byte
        assign word_kept[b*8 +: 8] = (3'(b) <= code_eff) ? word_in[b*8 +: 8] : 8'h00;
    end
endmodule

// File: rtl/pce_chan_slice.sv
module pce_chan_slice
    import pce_pkg::*;
#(
    parameter int PX_W = 32
) (
    input  logic [PX_W-1:0]  word_in,
    input  logic [SEL_W-1:0] sel,
    output logic [CH_W-1:0]  chan
);
    logic [LEN_W-1:0] len_raw;
    logic [LEN_W-1:0] len;
    logic [OFF_W-1:0] off;
    logic [PX_W-1:0]  shifted;
    logic [8:0]       len_mask;
    logic [CH_W-1:0]  field;
    logic [LEN_W-1:0] lift;
    logic [CH_W-1:0]  top_aligned;
    logic [CH_W-1:0]  filled;

    assign len_raw = sel[LEN_LSB +: LEN_W];
    assign len     = (len_raw > 4'd8) ? 4'd8 : len_raw;
    assign off     = sel[OFF_W-1:0];

    assign shifted     = word_in >> off;
    assign len_mask    = (9'd1 << len) - 9'd1;
    assign field       = shifted[CH_W-1:0] & len_mask[CH_W-1:0];
    assign lift        = 4'd8 - len;
    assign top_aligned = field << lift;

    always_comb begin
        filled = '0;
        for (int k = 0; k < CH_W; k++) begin
            if (k * int'(len) < CH_W)
                filled = filled | (top_aligned >> (k * int'(len)));
        end
    end

    assign chan = (len == 4'd0) ? '0 : filled;
endmodule

// File: rtl/pce_pixel_extract.sv
module pce_pixel_extract
    import pce_pkg::*;
#(
    parameter int PX_BYTES = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  px_vld,
    input  logic [PX_BYTES*8-1:0] px_word,
    input  logic [2:0]            fmt_bpp_m1,
    input  logic [11:0]           red_sel,
    input  logic [11:0]           grn_sel,
    input  logic [11:0]           blu_sel,
    output logic                  out_vld,
    output logic [7:0]            out_r,
    output logic [7:0]            out_g,
    output logic [7:0]            out_b
);
    localparam int PX_W   = PX_BYTES * 8;
    localparam int N_CHAN = 3;

    logic [PX_W-1:0]  kept;
    logic [SEL_W-1:0] sel_arr  [N_CHAN];
    logic [CH_W-1:0]  chan_arr [N_CHAN];
    pce_rgb_t         rgb_d, rgb_q;
    pce_state_e       st_q, st_d;

    assign sel_arr[0] = red_sel;
    assign sel_arr[1] = grn_sel;
    assign sel_arr[2] = blu_sel;

    pce_width_mask #(.PX_BYTES(PX_BYTES)) u_mask (
        .word_in   (px_word),
        .bpp_m1    (fmt_bpp_m1),
        .word_kept (kept)
    );

    for (genvar c = 0; c < N_CHAN; c++) begin : g_chan
        pce_chan_slice #(.PX_W(PX_W)) u_slice (
            .word_in (kept),
            .sel     (sel_arr[c]),
            .chan    (chan_arr[c])
        );
    end

    assign rgb_d = '{r: chan_arr[0], g: chan_arr[1], b: chan_arr[2]};

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: if (px_vld) st_d = ST_EMIT;
            ST_EMIT: if (!px_vld) st_d = ST_IDLE;
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      rgb_q <= '0;
        else if (px_vld) rgb_q <= rgb_d;
    end

    assign out_vld = (st_q == ST_EMIT);
    assign out_r   = rgb_q.r;
    assign out_g   = rgb_q.g;
    assign out_b   = rgb_q.b;

    // R2
    lat_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        px_vld |=> out_vld);
    // R2
    no_spurious_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !px_vld |=> !out_vld);
    // R3
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !px_vld |=> ($stable(out_r) && $stable(out_g) && $stable(out_b)));
    // R7
    zero_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (px_vld && red_sel[11:8] == 4'd0) |=> out_r == 8'h00);
    // R6
    one_bit_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (px_vld && grn_sel[11:8] == 4'd1) |=> (out_g == 8'h00 || out_g == 8'hFF));
    // R4
    byte_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (px_vld && fmt_bpp_m1 == 3'd0 && blu_sel[7:0] >= 8'd8) |=> out_b == 8'h00);
endmodule

// File: tb/test_pce_pixel_extract.sv
module test_pce_pixel_extract;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        px_vld = 1'b0;
    logic [31:0] px_word = '0;
    logic [2:0]  fmt_bpp_m1 = '0;
    logic [11:0] red_sel = '0, grn_sel = '0, blu_sel = '0;
    logic        out_vld;
    logic [7:0]  out_r, out_g, out_b;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    pce_pixel_extract i_pce_pixel_extract (
        .clk(clk), .rst_n(rst_n), .px_vld(px_vld), .px_word(px_word),
        .fmt_bpp_m1(fmt_bpp_m1), .red_sel(red_sel), .grn_sel(grn_sel),
        .blu_sel(blu_sel), .out_vld(out_vld), .out_r(out_r), .out_g(out_g),
        .out_b(out_b)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] model(input logic [31:0] w, input logic [2:0] code,
                                         input logic [11:0] sel);
        int nbytes = (code > 3) ? 4 : int'(code) + 1;
        int len = (int'(sel[11:8]) > 8) ? 8 : int'(sel[11:8]);
        int off = int'(sel[7:0]);
        logic [7:0] fld = '0;
        logic [7:0] res = '0;
        if (len == 0) return 8'h00;
        for (int j = 0; j < len; j++)
            if (off + j < 8 * nbytes) fld[j] = w[off + j];
        for (int i = 0; i < 8; i++)
            res[7 - i] = fld[len - 1 - (i % len)];
        return res;
    endfunction

    task automatic send(input logic [31:0] w);
        @(negedge clk);
        px_word = w;
        px_vld  = 1'b1;
        @(negedge clk);
        px_vld  = 1'b0;
    endtask

    task automatic expect_rgb(input string tag, input logic [7:0] er,
                              input logic [7:0] eg, input logic [7:0] eb);
        chk(out_vld == 1'b1, {tag, " vld"}, 32'(out_vld), 32'd1);
        chk(out_r == er, {tag, " red"}, 32'(out_r), 32'(er));
        chk(out_g == eg, {tag, " green"}, 32'(out_g), 32'(eg));
        chk(out_b == eb, {tag, " blue"}, 32'(out_b), 32'(eb));
    endtask

    task automatic run_model(input string tag, input logic [31:0] w);
        logic [7:0] er = model(w, fmt_bpp_m1, red_sel);
        logic [7:0] eg = model(w, fmt_bpp_m1, grn_sel);
        logic [7:0] eb = model(w, fmt_bpp_m1, blu_sel);
        send(w);
        expect_rgb(tag, er, eg, eb);
    endtask

    task automatic t_reset();
        chk(out_vld == 1'b0, "R1 vld", 32'(out_vld), 0);
        chk({out_r, out_g, out_b} == 24'h0, "R1 rgb", {8'h0, out_r, out_g, out_b}, 0);
    endtask

    task automatic t_rgb565();
        fmt_bpp_m1 = 3'd1;
        red_sel = {4'd5, 8'd11}; grn_sel = {4'd6, 8'd5}; blu_sel = {4'd5, 8'd0};
        send(32'h0000_8410); expect_rgb("R8 mid", 8'h84, 8'h82, 8'h84);
        send(32'h0000_F800); expect_rgb("R8 red", 8'hFF, 8'h00, 8'h00);
        send(32'h0000_07E0); expect_rgb("R8 green", 8'h00, 8'hFF, 8'h00);
        send(32'hFFFF_001F); expect_rgb("R8 blue upper ignored", 8'h00, 8'h00, 8'hFF);
    endtask

    task automatic t_truecolor();
        red_sel = {4'd8, 8'd16}; grn_sel = {4'd8, 8'd8}; blu_sel = {4'd8, 8'd0};
        fmt_bpp_m1 = 3'd3;
        send(32'h00AB_CDEF); expect_rgb("R9 a00", 8'hAB, 8'hCD, 8'hEF);
        send(32'hFFAB_CDEF); expect_rgb("R9 aFF", 8'hAB, 8'hCD, 8'hEF);
        fmt_bpp_m1 = 3'd2;
        red_sel = {4'd8, 8'd24};
        send(32'h5A12_3456); expect_rgb("R4 24bpp top byte masked", 8'h00, 8'h34, 8'h56);
        fmt_bpp_m1 = 3'd6;
        send(32'h5A12_3456); expect_rgb("R4 code6 as 4 bytes", 8'h5A, 8'h34, 8'h56);
        fmt_bpp_m1 = 3'd0;
        red_sel = {4'd8, 8'd4}; grn_sel = {4'd8, 8'd8}; blu_sel = {4'd4, 8'd0};
        run_model("R4 8bpp straddle", 32'hFFFF_FF9C);
        fmt_bpp_m1 = 3'd3;
        red_sel = {4'd8, 8'd28}; grn_sel = {4'd8, 8'd200}; blu_sel = {4'd8, 8'd31};
        run_model("R5 past word top", 32'hF000_0000 | 32'h8000_0000);
    endtask

    task automatic t_lengths();
        fmt_bpp_m1 = 3'd3;
        for (int l = 0; l < 16; l++) begin
            red_sel = {4'(l), 8'd0}; grn_sel = {4'(l), 8'd3}; blu_sel = {4'(l), 8'd21};
            run_model($sformatf("R6 R7 len %0d", l), 32'hA5C3_96E1);
        end
        red_sel = {4'd1, 8'd0}; grn_sel = {4'd3, 8'd0}; blu_sel = {4'd12, 8'd0};
        send(32'h0000_0005); expect_rgb("R6 fill 1/3 R7 clamp", 8'hFF, 8'hB6, 8'h05);
    endtask

    task automatic t_hold_and_change();
        fmt_bpp_m1 = 3'd3;
        red_sel = {4'd8, 8'd16}; grn_sel = {4'd8, 8'd8}; blu_sel = {4'd8, 8'd0};
        send(32'h0011_2233);
        expect_rgb("R2 first", 8'h11, 8'h22, 8'h33);
        red_sel = {4'd0, 8'd0}; fmt_bpp_m1 = 3'd0; px_word = 32'hFFFF_FFFF;
        @(negedge clk);
        chk(out_vld == 1'b0, "R2 single pulse", 32'(out_vld), 0);
        chk({out_r, out_g, out_b} == 24'h112233, "R3 hold after cfg change",
            {8'h0, out_r, out_g, out_b}, 32'h112233);
        repeat (3) @(negedge clk);
        chk({out_r, out_g, out_b} == 24'h112233, "R3 hold idle",
            {8'h0, out_r, out_g, out_b}, 32'h112233);
        send(32'h0044_5566);
        expect_rgb("R3 new cfg applied", 8'h00, 8'h00, 8'h66);
    endtask

    task automatic t_back_to_back();
        fmt_bpp_m1 = 3'd3;
        red_sel = {4'd8, 8'd16}; grn_sel = {4'd8, 8'd8}; blu_sel = {4'd8, 8'd0};
        @(negedge clk);
        px_word = 32'h0001_0203; px_vld = 1'b1;
        @(negedge clk);
        expect_rgb("R2 b2b A", 8'h01, 8'h02, 8'h03);
        px_word = 32'h00A0_B0C0; red_sel = {4'd4, 8'd20};
        @(negedge clk);
        px_vld = 1'b0;
        expect_rgb("R2 b2b B", 8'hAA, 8'hB0, 8'hC0);
        @(negedge clk);
        chk(out_vld == 1'b0, "R2 b2b end", 32'(out_vld), 0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_rgb565();
        t_truecolor();
        t_lengths();
        t_hold_and_change();
        t_back_to_back();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule